// File: doc/BRIEF.md
# Signed Multiply Decode-Execute Unit

This block takes a multiply instruction one byte at a time over a valid/ready handshake. It recognises a fixed escape byte, then an opcode byte that selects one of four signed multiply forms. The forms are a 16x16 word multiply or an 8x8 byte multiply, and each comes as a two-operand or a three-operand variant. The operand bytes that follow are register addresses into a 256-byte little-endian register file inside the block. After the last operand byte the unit reads both factors, forms the double-width two's-complement product and writes it to the destination register.

A host port preloads register bytes. A registered peek port reads them back, and a flag-load port sets the six-bit status word. The unit runs register-direct operands only. It decodes the other addressing-mode encodings, consumes their bytes and then reports them as unsupported without writing anything. A misaligned destination or source is reported as illegal, and so are a wrong leading byte and an unknown opcode.

Top module: `mul_exec_unit`

## Requirements
- R1: Every instruction begins with the byte 8'hFE. Any other byte accepted while waiting for that byte raises `illegal` in the cycle after it is accepted, and the unit keeps waiting for 8'hFE.
- R2: Bits [7:2] of the opcode byte select the form: 6'b011011 is word two-operand, 6'b010011 is word three-operand, 6'b011111 is byte two-operand and 6'b010111 is byte three-operand. Any other value raises `illegal`, and the next byte is treated as a new leading byte.
- R3: In the word two-operand form the bytes after the opcode are the source address, then the destination address. The signed 16-bit word at the destination times the source word is written as 32 bits, little-endian, at the destination and at the three bytes above it.
- R4: In the word three-operand form the bytes after the opcode are the second source, the first source and the destination. The 32-bit product of the two source words goes to the destination.
- R5: The byte forms multiply two signed 8-bit register bytes and write the 16-bit product, little-endian, at a word destination. They use the same operand order as the matching word forms.
- R6: Both factors are treated as two's-complement values, including the most negative values. `result` shows the product sign-extended to 32 bits.
- R7: The destination write and a one-cycle `done` pulse both happen in the cycle after the edge that accepts the last operand byte, and not before.
- R8: Status bits are [5] zero, [4] negative, [3] carry, [2] overflow, [1] overflow trap and [0] sticky. A completed multiply keeps bits [5:1] and clears bit [0].
- R9: An opcode whose mode field (bits [1:0]) is not 2'b00 consumes the same operand bytes. It then raises `unsupported` instead of `done`, and no register or status bit changes.
- R10: A long destination (word forms) must be 4-byte aligned, and word sources and word destinations (byte forms) must be 2-byte aligned. A violation raises `illegal` at execute time with no write.
- R11: `in_ready` is low during the execute cycle, and a byte offered then is ignored.
- R12: `done`, `illegal` and `unsupported` are single-cycle pulses, and at most one of them is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Instruction byte offered |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Unit can accept a byte |
| ld_en | input | 1 | Host register byte write |
| ld_addr | input | 8 | Host write address |
| ld_data | input | 8 | Host write data |
| pk_addr | input | 8 | Peek address |
| pk_data | output | 8 | Registered peek data |
| flag_ld | input | 1 | Load the status word |
| flag_din | input | 6 | Status word value to load |
| done | output | 1 | Multiply completed and written |
| illegal | output | 1 | Bad leading byte, opcode or alignment |
| unsupported | output | 1 | Non-register addressing mode |
| result | output | 32 | Last product, sign-extended |
| status | output | 6 | Status word |

## Verification
The hardest case to reach from the ports is a byte offered during the single execute cycle. The stimulus places it in the gap between the last operand byte and the `done` pulse, and it is a byte that would be flagged illegal if the unit took it. Alignment and mode faults need complete, well-formed byte streams that differ from a good instruction in one field only. The bench builds those streams and then reads the destination bytes back through the peek port to show that they are untouched.

// File: rtl/mul_exec_pkg.sv
package mul_exec_pkg;
  typedef enum logic [2:0] {
    ST_PREFIX, ST_OPCODE, ST_ARG0, ST_ARG1, ST_ARG2, ST_EXEC
  } dec_state_t;

  localparam logic [5:0] FORM_W2 = 6'b011011;
  localparam logic [5:0] FORM_W3 = 6'b010011;
  localparam logic [5:0] FORM_B2 = 6'b011111;
  localparam logic [5:0] FORM_B3 = 6'b010111;

  localparam int FLAGS_W    = 6;
  localparam int FLAG_STICK = 0;
endpackage

// File: rtl/mul_decoder.sv
module mul_decoder
  import mul_exec_pkg::*;
#(
  parameter int          ADDR_W = 8,
  parameter logic [7:0]  PREFIX = 8'hFE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [7:0]        in_byte,
  output logic              in_ready,
  output logic              bad_byte,
  output logic              exec,
  output logic              is_word,
  output logic [1:0]        mode,
  output logic [ADDR_W-1:0] src1,
  output logic [ADDR_W-1:0] src2,
  output logic [ADDR_W-1:0] dest
);
  dec_state_t state;
  logic accept, form_ok, f_word, f_three, is_three;
  logic [ADDR_W-1:0] arg0, arg1, arg2;

  assign in_ready = (state != ST_EXEC);
  assign accept   = in_valid && in_ready;
  assign exec     = (state == ST_EXEC);

  always_comb begin
    form_ok = 1'b1;
    f_word  = 1'b0;
    f_three = 1'b0;
    case (in_byte[7:2])
      FORM_W2: f_word = 1'b1;
      FORM_W3: begin f_word = 1'b1; f_three = 1'b1; end
      FORM_B2: ;
      FORM_B3: f_three = 1'b1;
      default: form_ok = 1'b0;
    endcase
  end

  assign bad_byte = accept &&
                    (((state == ST_PREFIX) && (in_byte != PREFIX)) ||
                     ((state == ST_OPCODE) && !form_ok));

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_PREFIX;
      is_word  <= 1'b0;
      is_three <= 1'b0;
      mode     <= 2'b00;
      arg0     <= '0;
      arg1     <= '0;
      arg2     <= '0;
    end else begin
      case (state)
        ST_PREFIX: if (accept && in_byte == PREFIX) state <= ST_OPCODE;
        ST_OPCODE: if (accept) begin
          if (form_ok) begin
            is_word  <= f_word;
            is_three <= f_three;
            mode     <= in_byte[1:0];
            state    <= ST_ARG0;
          end else begin
            state <= ST_PREFIX;
          end
        end
        ST_ARG0: if (accept) begin
          arg0  <= in_byte[ADDR_W-1:0];
          state <= ST_ARG1;
        end
        ST_ARG1: if (accept) begin
          arg1  <= in_byte[ADDR_W-1:0];
          state <= is_three ? ST_ARG2 : ST_EXEC;
        end
        ST_ARG2: if (accept) begin
          arg2  <= in_byte[ADDR_W-1:0];
          state <= ST_EXEC;
        end
        default: state <= ST_PREFIX;
      endcase
    end
  end

  // operand order: second source first, destination last; two-operand dest doubles as first source
  assign src2 = arg0;
  assign src1 = arg1;
  assign dest = is_three ? arg2 : arg1;

  p_bad_prefix_r1: assert property (@(posedge clk) disable iff (rst)
    (state == ST_PREFIX && in_valid && in_byte != PREFIX) |=> (state == ST_PREFIX));
  p_bad_opcode_r2: assert property (@(posedge clk) disable iff (rst)
    (state == ST_OPCODE && accept && !form_ok) |=> (state == ST_PREFIX));
  p_exec_single_r11: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EXEC) |=> (state == ST_PREFIX));
endmodule

// File: rtl/mul_regfile.sv
module mul_regfile #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              ld_en,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [7:0]        ld_data,
  input  logic              wr_en,
  input  logic              wr_wide,
  input  logic [ADDR_W-1:0] wr_base,
  input  logic [31:0]       wr_data,
  input  logic [ADDR_W-1:0] ra_addr,
  output logic [15:0]       ra_data,
  input  logic [ADDR_W-1:0] rb_addr,
  output logic [15:0]       rb_data,
  input  logic [ADDR_W-1:0] pk_addr,
  output logic [7:0]        pk_data
);
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [ADDR_W-1:0] ONE = ADDR_W'(1);

  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (ld_en) mem[ld_addr] <= ld_data;
    for (int i = 0; i < 4; i++) begin
      if (wr_en && (wr_wide || i < 2))
        mem[wr_base + ADDR_W'(i)] <= wr_data[8*i +: 8];
    end
    pk_data <= mem[pk_addr];
  end

  assign ra_data = {mem[ra_addr + ONE], mem[ra_addr]};
  assign rb_data = {mem[rb_addr + ONE], mem[rb_addr]};
endmodule

// File: rtl/mul_product.sv
module mul_product (
  input  logic        is_word,
  input  logic [15:0] fa,
  input  logic [15:0] fb,
  output logic [31:0] prod
);
  logic signed [15:0] sa, sb;
  logic signed [31:0] p;

  assign sa   = is_word ? fa : {{8{fa[7]}}, fa[7:0]};
  assign sb   = is_word ? fb : {{8{fb[7]}}, fb[7:0]};
  assign p    = sa * sb;
  assign prod = p;
endmodule

// File: rtl/mul_exec_unit.sv
module mul_exec_unit
  import mul_exec_pkg::*;
#(
  parameter int         ADDR_W = 8,
  parameter logic [7:0] PREFIX = 8'hFE
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               in_valid,
  input  logic [7:0]         in_byte,
  output logic               in_ready,
  input  logic               ld_en,
  input  logic [ADDR_W-1:0]  ld_addr,
  input  logic [7:0]         ld_data,
  input  logic [ADDR_W-1:0]  pk_addr,
  output logic [7:0]         pk_data,
  input  logic               flag_ld,
  input  logic [FLAGS_W-1:0] flag_din,
  output logic               done,
  output logic               illegal,
  output logic               unsupported,
  output logic [31:0]        result,
  output logic [FLAGS_W-1:0] status
);
  logic              bad_byte, exec, is_word, misalign, go, bad_mode;
  logic [1:0]        mode;
  logic [ADDR_W-1:0] src1, src2, dest;
  logic [15:0]       fa, fb;
  logic [31:0]       prod;

  mul_decoder #(.ADDR_W(ADDR_W), .PREFIX(PREFIX)) u_dec (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .bad_byte(bad_byte), .exec(exec),
    .is_word(is_word), .mode(mode), .src1(src1), .src2(src2), .dest(dest)
  );

  mul_regfile #(.ADDR_W(ADDR_W)) u_rf (
    .clk(clk), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .wr_en(go), .wr_wide(is_word), .wr_base(dest), .wr_data(prod),
    .ra_addr(src1), .ra_data(fa), .rb_addr(src2), .rb_data(fb),
    .pk_addr(pk_addr), .pk_data(pk_data)
  );

  mul_product u_mul (.is_word(is_word), .fa(fa), .fb(fb), .prod(prod));

  assign bad_mode = (mode != 2'b00);
  assign misalign = is_word ? ((dest[1:0] != 2'b00) || src1[0] || src2[0])
                            : dest[0];
  assign go       = exec && !bad_mode && !misalign;

  always_ff @(posedge clk) begin
    if (rst) begin
      done        <= 1'b0;
      illegal     <= 1'b0;
      unsupported <= 1'b0;
      result      <= '0;
      status      <= '0;
    end else begin
      done        <= go;
      illegal     <= bad_byte || (exec && !bad_mode && misalign);
      unsupported <= exec && bad_mode;
      if (go) result <= prod;
      if (flag_ld) status <= flag_din;
      if (go) status[FLAG_STICK] <= 1'b0;
    end
  end

  p_pulse_excl_r12: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, illegal, unsupported}));
  p_status_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !$past(flag_ld) |-> (status[FLAGS_W-1:1] == $past(status[FLAGS_W-1:1])));
  p_sticky_clear_r8: assert property (@(posedge clk) disable iff (rst)
    done |-> !status[FLAG_STICK]);
  p_done_after_exec_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> $past(exec));
  p_unsup_mode_r9: assert property (@(posedge clk) disable iff (rst)
    unsupported |-> ($past(mode) != 2'b00));
endmodule

// File: tb/mul_exec_unit_test.sv
module mul_exec_unit_test;
  logic clk = 1'b0, rst = 1'b1;
  logic in_valid = 1'b0, ld_en = 1'b0, flag_ld = 1'b0;
  logic [7:0] in_byte = '0, ld_addr = '0, ld_data = '0, pk_addr = '0;
  logic [5:0] flag_din = '0;
  logic in_ready, done, illegal, unsupported;
  logic [7:0] pk_data;
  logic [31:0] result;
  logic [5:0] status;

  int checks = 0, fails = 0;
  logic c_early, c_done, c_ill, c_uns;
  logic [31:0] c_res;

  always #10 clk = ~clk;

  mul_exec_unit uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .ld_en(ld_en), .ld_addr(ld_addr), .ld_data(ld_data),
    .pk_addr(pk_addr), .pk_data(pk_data), .flag_ld(flag_ld),
    .flag_din(flag_din), .done(done), .illegal(illegal),
    .unsupported(unsupported), .result(result), .status(status)
  );

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  // all tasks start and end just after a falling edge
  task automatic send(input logic [7:0] b);
    in_valid = 1'b1; in_byte = b;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic load(input logic [7:0] a, input logic [7:0] d);
    ld_en = 1'b1; ld_addr = a; ld_data = d;
    @(negedge clk);
    ld_en = 1'b0;
  endtask

  task automatic load16(input logic [7:0] a, input logic [15:0] d);
    load(a, d[7:0]);
    load(a + 8'd1, d[15:8]);
  endtask

  task automatic peek(input logic [7:0] a, output logic [7:0] d);
    pk_addr = a;
    @(negedge clk);
    d = pk_data;
  endtask

  task automatic peek32(input logic [7:0] a, output logic [31:0] d);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] t;
      peek(a + 8'(i), t);
      d[8*i +: 8] = t;
    end
  endtask

  task automatic set_flags(input logic [5:0] f);
    flag_ld = 1'b1; flag_din = f;
    @(negedge clk);
    flag_ld = 1'b0;
  endtask

  task automatic issue(input int n, input logic [7:0] b0, input logic [7:0] b1,
                       input logic [7:0] b2, input logic [7:0] b3, input logic [7:0] b4);
    send(b0); send(b1); send(b2); send(b3);
    if (n > 4) send(b4);
    c_early = done;
    @(negedge clk);
    c_done = done; c_ill = illegal; c_uns = unsupported; c_res = result;
  endtask

  function automatic logic [7:0] bval(input int i);
    logic [7:0] v;
    v = 8'(i * 17);
    return (i >= 16) ? (v ^ 8'h80) : v;
  endfunction

  function automatic logic [15:0] wval(input int i);
    case (i)
      0: return 16'h0000; 1: return 16'h0001; 2: return 16'hFFFF;
      3: return 16'h7FFF; 4: return 16'h8000; 5: return 16'h8001;
      6: return 16'h00FF; 7: return 16'hFF00;
      default: return 16'(i * 16'h2469 + 16'h0135);
    endcase
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL R7 watchdog got %0d cycles expected fewer", 150000);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] got32;
    logic [7:0]  g8;
    int e;
    logic [5:0] fl;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // reset state
    chk("R12 reset pulses", {29'd0, done, illegal, unsupported}, 32'd0);
    chk("R8 reset status", {26'd0, status}, 32'd0);
    chk("R11 reset ready", {31'd0, in_ready}, 32'd1);

    fl = 6'b101011;
    set_flags(fl);

    // byte three-operand sweep: FE, 5C, src2, src1, dest
    for (int i = 0; i < 32; i++) begin
      for (int j = 0; j < 32; j++) begin
        logic [7:0] a, b;
        a = bval(i); b = bval(j);
        load(8'h10, a); load(8'h11, b);
        issue(5, 8'hFE, 8'h5C, 8'h10, 8'h11, 8'h20);
        e = $signed(a) * $signed(b);
        chk("R7 no early done", {31'd0, c_early}, 32'd0);
        chk("R7 done pulse", {31'd0, c_done}, 32'd1);
        chk("R5 R6 byte3 result", c_res, 32'(e));
        peek(8'h20, g8); got32[7:0] = g8;
        peek(8'h21, g8); got32[15:8] = g8;
        chk("R5 byte3 stored", {16'd0, got32[15:0]}, {16'd0, 16'(e)});
        chk("R8 status", {26'd0, status}, {26'd0, fl[5:1], 1'b0});
        chk("R12 done pulse length", {31'd0, done}, 32'd0);
      end
    end

    // byte two-operand: FE, 7C, src, dest ; dest low byte times src
    fl = 6'b010101;
    set_flags(fl);
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [7:0] a, b;
        a = bval(i + 16); b = bval(j);
        load(8'h30, a); load(8'h31, 8'h5A); load(8'h12, b);
        issue(4, 8'hFE, 8'h7C, 8'h12, 8'h30, 8'h00);
        e = $signed(a) * $signed(b);
        chk("R5 byte2 done", {31'd0, c_done}, 32'd1);
        chk("R5 R6 byte2 result", c_res, 32'(e));
        peek(8'h30, g8); got32[7:0] = g8;
        peek(8'h31, g8); got32[15:8] = g8;
        chk("R5 byte2 stored", {16'd0, got32[15:0]}, {16'd0, 16'(e)});
        chk("R8 status byte2", {26'd0, status}, {26'd0, fl[5:1], 1'b0});
      end
    end

    // word three-operand: FE, 4C, src2, src1, dest
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 16; j++) begin
        logic [15:0] a, b;
        a = wval(i); b = wval(j);
        load16(8'h40, b); load16(8'h42, a);
        issue(5, 8'hFE, 8'h4C, 8'h40, 8'h42, 8'h48);
        e = $signed(a) * $signed(b);
        chk("R4 word3 done", {31'd0, c_done}, 32'd1);
        chk("R4 R6 word3 result", c_res, 32'(e));
        peek32(8'h48, got32);
        chk("R4 word3 stored", got32, 32'(e));
      end
    end

    // word two-operand: FE, 6C, src, dest ; low word of dest times src
    for (int i = 0; i < 16; i++) begin
      for (int j = 0; j < 8; j++) begin
        logic [15:0] a, b;
        a = wval(i); b = wval(j + 3);
        load16(8'h50, a); load16(8'h52, 16'hC3C3); load16(8'h44, b);
        issue(4, 8'hFE, 8'h6C, 8'h44, 8'h50, 8'h00);
        e = $signed(a) * $signed(b);
        chk("R3 word2 done", {31'd0, c_done}, 32'd1);
        chk("R3 R6 word2 result", c_res, 32'(e));
        peek32(8'h50, got32);
        chk("R3 word2 stored", got32, 32'(e));
      end
    end

    // R1 bad leading byte
    send(8'h00);
    chk("R1 illegal on bad prefix", {31'd0, illegal}, 32'd1);
    @(negedge clk);
    chk("R12 illegal one cycle", {31'd0, illegal}, 32'd0);
    load(8'h10, 8'h03); load(8'h11, 8'h05);
    issue(5, 8'hFE, 8'h5C, 8'h10, 8'h11, 8'h20);
    chk("R1 recovers after bad prefix", c_res, 32'd15);

    // R2 bad opcode, then the next byte is a new prefix
    send(8'hFE); send(8'h00);
    chk("R2 illegal on bad opcode", {31'd0, illegal}, 32'd1);
    @(negedge clk);
    load(8'h10, 8'hF9);
    issue(5, 8'hFE, 8'h5C, 8'h10, 8'h11, 8'h20);
    chk("R2 recovers after bad opcode", c_res, 32'hFFFFFFDD);

    // R9 unsupported mode: no write, no done, status kept
    set_flags(6'b000001);
    load16(8'h60, 16'hBEEF);
    issue(5, 8'hFE, 8'h5D, 8'h10, 8'h11, 8'h60);
    chk("R9 unsupported pulse", {29'd0, c_done, c_ill, c_uns}, 32'd1);
    peek(8'h60, g8); got32[7:0] = g8;
    peek(8'h61, g8); got32[15:8] = g8;
    chk("R9 dest unchanged", {16'd0, got32[15:0]}, 32'h0000BEEF);
    chk("R9 status unchanged", {26'd0, status}, 32'd1);
    chk("R9 result unchanged", result, 32'hFFFFFFDD);

    // R10 misaligned long destination
    load16(8'h49, 16'h1234); load16(8'h4B, 16'h5678);
    issue(5, 8'hFE, 8'h4C, 8'h40, 8'h42, 8'h49);
    chk("R10 misaligned long dest", {29'd0, c_done, c_ill, c_uns}, 32'd2);
    peek32(8'h49, got32);
    chk("R10 long dest unchanged", got32, 32'h56781234);
    // misaligned word source
    issue(5, 8'hFE, 8'h4C, 8'h41, 8'h42, 8'h48);
    chk("R10 misaligned word source", {29'd0, c_done, c_ill, c_uns}, 32'd2);
    // byte form odd destination
    load16(8'h21, 16'hA55A);
    issue(5, 8'hFE, 8'h5C, 8'h10, 8'h11, 8'h21);
    chk("R10 misaligned word dest", {29'd0, c_done, c_ill, c_uns}, 32'd2);
    peek(8'h21, g8);
    chk("R10 word dest unchanged", {24'd0, g8}, 32'h5A);

    // R11 byte offered in the execute cycle is ignored
    load(8'h10, 8'h07); load(8'h11, 8'h06);
    send(8'hFE); send(8'h5C); send(8'h10); send(8'h11); send(8'h20);
    chk("R11 ready low in execute", {31'd0, in_ready}, 32'd0);
    in_valid = 1'b1; in_byte = 8'h00;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R11 done despite offered byte", {30'd0, done, illegal}, 32'd2);
    @(negedge clk);
    chk("R11 offered byte ignored", {30'd0, done, illegal}, 32'd0);
    chk("R7 result after ignore", result, 32'd42);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule